// File: doc/BRIEF.md
# Qualified Performance Event Counter

A single hardware performance-monitoring counter that adds an incoming per-cycle event count into a wide accumulator, but only in cycles where every qualifier passes. There are three qualifiers. A privilege filter selects kernel level, user levels or both. A filter on the activity of two logical processors selects one of four patterns. A threshold stage compares the event count against a programmed value, can invert that comparison, and can count only the rising edges of its result.

Software programs a configuration word and can read or preload the counter through a small register port with four word addresses. When the accumulator wraps past all-ones, a sticky overflow flag is set. An interrupt output follows that flag while interrupt delivery is enabled.

Top module: `qual_event_counter`

## Requirements
- R1: After reset the counter is zero, the overflow flag and `irqOut` are low, and the configuration word reads 0x010. That value means counting is disabled and the activity selector holds code 2 ("both").
- R2: The register port has four word addresses. Address 0 is the configuration word, address 1 holds counter bits 31:0, address 2 holds the upper counter bits zero-extended, and address 3 is status, with bit 0 as the overflow flag. A configuration write takes effect from the next cycle. The configuration fields are: bit 0 enable, bit 1 kernel enable, bit 2 user enable, bits 4:3 activity selector, bit 5 threshold mode, bit 6 complement, bit 7 edge, bits 11:8 threshold, and bit 12 interrupt enable.
- R3: With threshold mode off, each qualifying cycle adds the raw 4-bit event count (0 to 15) to the 40-bit counter.
- R4: With threshold mode on and complement off, a qualifying cycle adds exactly 1 when the event count is strictly greater than the threshold. An equal count adds nothing.
- R5: With threshold mode and complement both on, a qualifying cycle adds exactly 1 when the event count is strictly less than the threshold. An equal count adds nothing.
- R6: Edge mode with threshold mode on adds 1 only on a false-to-true change of the comparison result. The previous result is cleared while the counter is disabled. Edge mode has no effect when threshold mode is off.
- R7: Privilege level 0 is counted when the kernel enable is set. Levels 1 to 3 are counted when the user enable is set. When both enables are clear, every level is counted.
- R8: The activity selector acts on the two activity bits as follows. Code 0 counts when neither bit is set. Code 1 counts when exactly one bit is set. Code 2 counts when both bits are set. Code 3 counts when at least one bit is set.
- R9: While the enable bit is clear, the counter does not change except through software writes.
- R10: A software write to either counter half in a cycle replaces that half and suppresses any increment in the same cycle.
- R11: A wrap from all-ones sets the sticky overflow flag. `irqOut` is high while the flag and the interrupt enable are both set. Writing 1 to status bit 0 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtCount | input | 4 | Event count for this cycle |
| privLevel | input | 2 | Current privilege level (0 kernel, 1 to 3 user) |
| thrActive | input | 2 | Activity flag of each of the two logical processors |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| irqOut | output | 1 | Overflow interrupt |

## Verification
The assertions assume that `regAddr` and `regWrData` are valid whenever `regWrEn` is high. They also assume that a counter write and a status clear never target the same cycle, which holds because one address is decoded per cycle. The step-size properties depend on the event count being a 4-bit value, so the counter can never gain more than 15 in a single cycle. The bench changes all inputs only at falling edges and configures each scenario with the counter disabled. Its counts therefore start from a known edge, and every counted cycle sees a stable event count, privilege level and activity pattern.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int EVT_W = 4;
  localparam int REG_W = 32;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_SINGLE = 2'd1,
    ACT_BOTH   = 2'd2,
    ACT_ANY    = 2'd3
  } actSel_e;

  typedef struct packed {
    logic             irqEn;
    logic [EVT_W-1:0] threshold;
    logic             edgeOn;
    logic             complement;
    logic             thrOn;
    actSel_e          actSel;
    logic             usrEn;
    logic             osEn;
    logic             enable;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic             inc;
    logic [EVT_W-1:0] incAmt;
    logic             loadLo;
    logic             loadHi;
    logic             ovfClr;
  } strobe_t;
endpackage

// File: rtl/qec_ctrl.sv
module qec_ctrl
  import qec_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [EVT_W-1:0]        evtCount,
  input  logic [1:0]              privLevel,
  input  logic [1:0]              thrActive,
  input  logic                    regWrEn,
  input  logic [1:0]              regAddr,
  input  logic [CFG_W-1:0]        cfgWrData,
  output cfg_t                    cfg,
  output strobe_t                 strobe
);
  cfg_t cfgQ;
  logic prevCmp;
  logic cmpHit;
  logic privOk;
  logic actOk;
  logic qualified;
  logic bothOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ        <= '0;
      cfgQ.actSel <= ACT_BOTH;
    end else if (regWrEn && regAddr == ADDR_CFG) begin
      cfgQ <= cfg_t'(cfgWrData);
    end
  end

  assign cmpHit = cfgQ.complement ? (evtCount < cfgQ.threshold)
                                  : (evtCount > cfgQ.threshold);

  // previous comparison result, forgotten while disabled
  always_ff @(posedge clk) begin
    if (!rstN)             prevCmp <= 1'b0;
    else if (!cfgQ.enable) prevCmp <= 1'b0;
    else                   prevCmp <= cmpHit;
  end

  assign bothOff = !cfgQ.osEn && !cfgQ.usrEn;
  assign privOk  = (privLevel == 2'd0) ? (cfgQ.osEn || bothOff)
                                       : (cfgQ.usrEn || bothOff);

  always_comb begin
    unique case (cfgQ.actSel)
      ACT_NONE:   actOk = (thrActive == 2'b00);
      ACT_SINGLE: actOk = (thrActive == 2'b01) || (thrActive == 2'b10);
      ACT_BOTH:   actOk = (thrActive == 2'b11);
      default:    actOk = (thrActive != 2'b00);
    endcase
  end

  assign qualified = cfgQ.enable && privOk && actOk;

  always_comb begin
    strobe = '0;
    if (!cfgQ.thrOn) begin
      strobe.inc    = qualified && (evtCount != '0);
      strobe.incAmt = evtCount;
    end else if (cfgQ.edgeOn) begin
      strobe.inc    = qualified && cmpHit && !prevCmp;
      strobe.incAmt = EVT_W'(1);
    end else begin
      strobe.inc    = qualified && cmpHit;
      strobe.incAmt = EVT_W'(1);
    end
    strobe.loadLo = regWrEn && (regAddr == ADDR_LO);
    strobe.loadHi = regWrEn && (regAddr == ADDR_HI);
    strobe.ovfClr = regWrEn && (regAddr == ADDR_STAT) && cfgWrData[0];
  end

  assign cfg = cfgQ;
endmodule

// File: rtl/qec_datapath.sv
module qec_datapath
  import qec_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [REG_W-1:0] regWrData,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int HI_W = CNT_W - REG_W;

  logic [CNT_W:0] sum;
  logic           anyLoad;

  assign sum     = {1'b0, cnt} + {{(CNT_W + 1 - EVT_W){1'b0}}, strobe.incAmt};
  assign anyLoad = strobe.loadLo || strobe.loadHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (anyLoad) begin
      if (strobe.loadLo) cnt[REG_W-1:0]     <= regWrData;
      if (strobe.loadHi) cnt[CNT_W-1:REG_W] <= regWrData[HI_W-1:0];
    end else if (strobe.inc) begin
      cnt <= sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  ovf <= 1'b0;
    else if (strobe.inc && !anyLoad && sum[CNT_W]) ovf <= 1'b1;
    else if (strobe.ovfClr)                     ovf <= 1'b0;
  end
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       evtCount,
  input  logic [1:0]       privLevel,
  input  logic [1:0]       thrActive,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             irqOut
);
  localparam int HI_W = CNT_W - REG_W;

  cfg_t             cfg;
  strobe_t          strobe;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  qec_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtCount  (evtCount),
    .privLevel (privLevel),
    .thrActive (thrActive),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .cfgWrData (regWrData[CFG_W-1:0]),
    .cfg       (cfg),
    .strobe    (strobe)
  );

  qec_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .cnt       (cnt),
    .ovf       (ovf)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_CFG: regRdData = {{(REG_W - CFG_W){1'b0}}, cfg};
      ADDR_LO:  regRdData = cnt[REG_W-1:0];
      ADDR_HI:  regRdData = {{(2 * REG_W - CNT_W){1'b0}}, cnt[CNT_W-1:REG_W]};
      default:  regRdData = {{(REG_W - 1){1'b0}}, ovf};
    endcase
  end

  assign irqOut = ovf && cfg.irqEn;

  logic unusedHi;
  assign unusedHi = ^HI_W;
endmodule

// File: rtl/qec_checker.sv
module qec_checker
  import qec_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic [1:0]       privLevel,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input cfg_t             cfg
);
  logic cntWr;
  logic ovfClrWr;
  assign cntWr    = regWrEn && (regAddr == ADDR_LO || regAddr == ADDR_HI);
  assign ovfClrWr = regWrEn && (regAddr == ADDR_STAT) && regWrData[0];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.enable && !cntWr) |=> $stable(cnt)); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_LO) |=> (cnt[31:0] == $past(regWrData))); // R10

  AST_RAW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr) |=> (CNT_W'(cnt - $past(cnt)) <= CNT_W'(15))); // R3

  AST_THR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.thrOn && !cntWr) |=> (CNT_W'(cnt - $past(cnt)) <= CNT_W'(1))); // R4

  AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (privLevel == 2'd0 && cfg.usrEn && !cfg.osEn && !cntWr) |=> $stable(cnt)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !ovfClrWr) |=> ovf); // R11

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr) |=> ((cnt >= $past(cnt)) || ovf)); // R11
endmodule

bind qual_event_counter qec_checker #(.CNT_W(CNT_W)) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .privLevel (privLevel),
  .cnt       (cnt),
  .ovf       (ovf),
  .cfg       (cfg)
);

// File: tb/test_qual_event_counter.sv
`timescale 1ns/1ps
module test_qual_event_counter;
  localparam logic [31:0] EN    = 32'h001;
  localparam logic [31:0] OS    = 32'h002;
  localparam logic [31:0] USR   = 32'h004;
  localparam logic [31:0] THR   = 32'h020;
  localparam logic [31:0] CMPL  = 32'h040;
  localparam logic [31:0] EDGE  = 32'h080;
  localparam logic [31:0] IRQ   = 32'h1000;
  localparam logic [31:0] ANY   = 32'h018;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  evtCount = '0;
  logic [1:0]  privLevel = '0;
  logic [1:0]  thrActive = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  qual_event_counter i_qual_event_counter (
    .clk(clk), .rstN(rstN), .evtCount(evtCount), .privLevel(privLevel),
    .thrActive(thrActive), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic clearCnt();
    wrReg(2'd1, 32'h0);
    wrReg(2'd2, 32'h0);
  endtask

  // exactly n clock edges see the given configuration
  task automatic runCount(input logic [31:0] cfg, input int n);
    wrReg(2'd0, cfg);
    repeat (n - 1) @(negedge clk);
    wrReg(2'd0, cfg & ~EN);
  endtask

  task automatic expectCount(input string req, input int n);
    logic [31:0] v;
    rdReg(2'd1, v);
    chk(req, v, n);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdReg(2'd0, v); chk("R1 cfg reset", v, 32'h010);
    rdReg(2'd1, v); chk("R1 cnt lo reset", v, 0);
    rdReg(2'd2, v); chk("R1 cnt hi reset", v, 0);
    rdReg(2'd3, v); chk("R1 status reset", v, 0);
    chk("R1 irq reset", {31'b0, irqOut}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wrReg(2'd0, 32'h0000_1ABE);
    rdReg(2'd0, v); chk("R2 cfg readback", v, 32'h0000_1ABE);
    wrReg(2'd0, 32'h0);
  endtask

  task automatic t_raw();
    clearCnt(); evtCount = 4'd7; thrActive = 2'b11;
    runCount(EN | OS | USR | ANY, 4);
    expectCount("R3 raw add 7x4", 28);
    clearCnt(); evtCount = 4'd3;
    runCount(EN | ANY | EDGE, 5);
    expectCount("R6 edge ignored without threshold", 15);
  endtask

  task automatic t_thr();
    clearCnt(); evtCount = 4'd6;
    runCount(EN | ANY | THR | 32'h500, 6);
    expectCount("R4 greater than threshold", 6);
    clearCnt(); evtCount = 4'd5;
    runCount(EN | ANY | THR | 32'h500, 6);
    expectCount("R4 equal to threshold", 0);
  endtask

  task automatic t_cmpl();
    clearCnt(); evtCount = 4'd4;
    runCount(EN | ANY | THR | CMPL | 32'h500, 3);
    expectCount("R5 less than threshold", 3);
    clearCnt(); evtCount = 4'd5;
    runCount(EN | ANY | THR | CMPL | 32'h500, 3);
    expectCount("R5 equal to threshold", 0);
  endtask

  task automatic t_edge();
    clearCnt(); evtCount = 4'd9;
    runCount(EN | ANY | THR | EDGE | 32'h200, 5);
    expectCount("R6 steady true counts once", 1);
    runCount(EN | ANY | THR | EDGE | 32'h200, 5);
    expectCount("R6 history cleared on disable", 2);
    clearCnt(); evtCount = 4'd0;
    wrReg(2'd0, EN | ANY | THR | EDGE | 32'h200);
    for (int i = 0; i < 5; i++) begin
      evtCount = (i % 2 == 0) ? 4'd9 : 4'd0;
      @(negedge clk);
    end
    wrReg(2'd0, ANY | THR | EDGE | 32'h200);
    expectCount("R6 alternating edges", 3);
  endtask

  task automatic t_priv();
    evtCount = 4'd1;
    clearCnt(); privLevel = 2'd2;
    runCount(EN | ANY | OS, 4);
    expectCount("R7 kernel-only blocks level 2", 0);
    clearCnt(); privLevel = 2'd0;
    runCount(EN | ANY | OS, 4);
    expectCount("R7 kernel-only counts level 0", 4);
    clearCnt(); privLevel = 2'd3;
    runCount(EN | ANY | USR, 4);
    expectCount("R7 user-only counts level 3", 4);
    clearCnt(); privLevel = 2'd0;
    runCount(EN | ANY | USR, 4);
    expectCount("R7 user-only blocks level 0", 0);
    clearCnt(); privLevel = 2'd1;
    runCount(EN | ANY, 4);
    expectCount("R7 neither set counts all", 4);
    privLevel = 2'd0;
  endtask

  task automatic t_thread();
    evtCount = 4'd1;
    for (int sel = 0; sel < 4; sel++) begin
      for (int act = 0; act < 4; act++) begin
        bit pass;
        case (sel)
          0: pass = (act == 0);
          1: pass = (act == 1) || (act == 2);
          2: pass = (act == 3);
          default: pass = (act != 0);
        endcase
        clearCnt(); thrActive = 2'(act);
        runCount(EN | OS | USR | (32'(sel) << 3), 2);
        expectCount($sformatf("R8 sel=%0d act=%0d", sel, act), pass ? 2 : 0);
      end
    end
    thrActive = 2'b11;
  endtask

  task automatic t_disable();
    clearCnt(); evtCount = 4'd15;
    runCount(OS | USR | ANY, 3);
    expectCount("R9 disabled holds", 0);
  endtask

  task automatic t_wrprio();
    logic [31:0] v;
    clearCnt(); evtCount = 4'd15;
    wrReg(2'd0, EN | ANY);
    wrReg(2'd1, 32'h100);
    rdReg(2'd1, v); chk("R10 lo write wins", v, 32'h100);
    wrReg(2'd2, 32'hAB);
    rdReg(2'd2, v); chk("R10 hi write", v, 32'hAB);
    rdReg(2'd1, v); chk("R10 hi write suppresses increment", v, 32'h100);
    wrReg(2'd0, ANY);
  endtask

  task automatic t_ovf();
    logic [31:0] v;
    wrReg(2'd1, 32'hFFFF_FFFE);
    wrReg(2'd2, 32'hFF);
    evtCount = 4'd3;
    rdReg(2'd3, v); chk("R11 no flag before wrap", v, 0);
    runCount(EN | ANY | IRQ, 1);
    rdReg(2'd1, v); chk("R11 wrapped lo", v, 1);
    rdReg(2'd2, v); chk("R11 wrapped hi", v, 0);
    rdReg(2'd3, v); chk("R11 flag set", v, 1);
    chk("R11 irq asserted", {31'b0, irqOut}, 1);
    wrReg(2'd0, ANY);
    chk("R11 irq masked", {31'b0, irqOut}, 0);
    rdReg(2'd3, v); chk("R11 flag sticky", v, 1);
    wrReg(2'd3, 32'h1);
    rdReg(2'd3, v); chk("R11 flag cleared", v, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    thrActive = 2'b11;
    t_raw();
    t_thr();
    t_cmpl();
    t_edge();
    t_priv();
    t_thread();
    t_disable();
    t_wrprio();
    t_ovf();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule